// File: doc/BRIEF.md
# Coprocessor Interrupt Priority Arbiter

This block chooses which pending interrupt a coprocessor core takes at an instruction boundary. It watches four request lines: a non-maskable request from the host, a timer request, a DMA-complete request and a maskable request from the host. The core marks the last cycle of each instruction with `boundary_i`. In that cycle the arbiter picks at most one source and emits a one-cycle `take_o` strobe. With the strobe it latches the vector the core must jump to, the new status byte, the status byte to push and whether the program bank is pushed.

Each source has a clear bit, and the three maskable sources also have an enable bit. The non-maskable source ignores the core's interrupt-disable flag and has its own vector. The maskable sources are tried in the order timer, DMA, host request, but only while the disable flag is low, and they share a second vector. When a source is taken, its status flag is set and its own clear bit is set. The source cannot fire again until software writes that clear bit back to 0. While the core is held in ready-wait or reset, no arbitration happens.

Top module: `cop_irq_arbiter`

## Requirements
- R1: After reset, `take_o` and `wake_o` are 0, `flags_o` and `clr_o` are 0, and `vec_o` is 0x0000.
- R2: A source is accepted only on a clock edge where `boundary_i` is 1 and `hold_i` is 0. At any other edge, `take_o` is 0 in the following cycle.
- R3: A non-maskable request (`nmi_req_i`=1 with `clr_o[0]`=0) is taken even when `idis_i`=1 and wins over every maskable source. Taking it latches `nmi_vec_i` into `vec_o` and sets `flags_o[0]` and `clr_o[0]`, so it fires once.
- R4: While `idis_i`=1, no maskable source is taken.
- R5: A maskable source qualifies when its request, its enable bit and a low clear bit all hold. Enable bits are `mask_en_i[0]` timer, `[1]` DMA and `[2]` host. Clear and flag bits are bit 1 timer, bit 2 DMA and bit 3 host. Among qualified sources the timer wins over DMA, and DMA wins over host.
- R6: A taken maskable source latches `irq_vec_i` into `vec_o` and sets its own flag bit and its own clear bit. It is not taken again until its clear bit is written to 0.
- R7: `wake_o` is 1 in exactly the cycles where `take_o` is 1.
- R8: In the cycle `take_o` is 1, `pbank_o` is 0x00. `p_new_o` equals the sampled `p_i` with bit 2 set and bit 3 cleared. `p_push_o` equals `p_i`, with bit 4 forced to 0 when `emu_i`=1. `push_bank_o` equals `!emu_i`.
- R9: A write (`clr_we_i`=1) loads `clr_wdata_i` into the clear bits and clears every flag whose written bit is 1. If a take happens on the same edge, the taken source's clear bit and flag end up 1.
- R10: Each acceptance gives a `take_o` pulse of exactly one cycle. Holding `boundary_i` with no new qualified source gives no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Last cycle of an instruction |
| hold_i | input | 1 | Core held in ready-wait or reset |
| nmi_req_i | input | 1 | Non-maskable host request |
| tmr_req_i | input | 1 | Timer request |
| dma_req_i | input | 1 | DMA-complete request |
| hirq_req_i | input | 1 | Maskable host request |
| mask_en_i | input | 3 | Enables: timer, DMA, host |
| clr_we_i | input | 1 | Clear-register write strobe |
| clr_wdata_i | input | 4 | Clear bits to write: NMI, timer, DMA, host |
| nmi_vec_i | input | 16 | Non-maskable vector |
| irq_vec_i | input | 16 | Shared maskable vector |
| idis_i | input | 1 | Core interrupt-disable flag |
| emu_i | input | 1 | Core emulation mode |
| p_i | input | 8 | Core status byte |
| take_o | output | 1 | One-cycle accept strobe |
| wake_o | output | 1 | Exit wait-for-interrupt |
| vec_o | output | 16 | Latched vector |
| flags_o | output | 4 | Per-source status flags |
| clr_o | output | 4 | Per-source clear bits |
| pbank_o | output | 8 | Program bank on entry |
| p_new_o | output | 8 | Status byte after entry |
| p_push_o | output | 8 | Status byte to push |
| push_bank_o | output | 1 | Program bank is pushed |

## Verification
A take and a software write to the clear register can land on the same edge, and both touch the same clear and flag bits. The bench provokes this by raising `boundary_i` together with `clr_we_i` while a request is pending. In that write, the taken source's bit is written as 0 and another source's bit is written as 1. The check is that the taken source keeps its clear bit and flag at 1, while the other bits follow the write.

// File: rtl/cop_irq_pkg.sv
package cop_irq_pkg;
  localparam int NSRC = 4;
  localparam int P_W  = 8;

  // source slots: 0 non-maskable, 1 timer, 2 DMA, 3 host request
  typedef enum logic [1:0] {
    SRC_NMI  = 2'd0,
    SRC_TMR  = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_HIRQ = 2'd3
  } src_e;

  // one-hot winner; slot 0 ignores the disable flag, lower slots win
  function automatic logic [NSRC-1:0] pick_winner(input logic [NSRC-1:0] qual,
                                                  input logic idis);
    logic [NSRC-1:0] w;
    w = '0;
    if (qual[SRC_NMI]) begin
      w[SRC_NMI] = 1'b1;
    end else if (!idis) begin
      for (int i = NSRC - 1; i >= 1; i--) begin
        if (qual[i]) w = NSRC'(1) << i;
      end
    end
    return w;
  endfunction

  function automatic logic [P_W-1:0] entry_status(input logic [P_W-1:0] p,
                                                  input int i_bit,
                                                  input int d_bit);
    logic [P_W-1:0] r;
    r = p;
    r[i_bit] = 1'b1;
    r[d_bit] = 1'b0;
    return r;
  endfunction

  function automatic logic [P_W-1:0] stacked_status(input logic [P_W-1:0] p,
                                                    input logic emu,
                                                    input int b_bit);
    logic [P_W-1:0] r;
    r = p;
    if (emu) r[b_bit] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/cop_irq_qualify.sv
module cop_irq_qualify
  import cop_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] qual
);
  for (genvar k = 0; k < NSRC; k++) begin : g_q
    assign qual[k] = req[k] & en[k] & ~clr[k];
  end
endmodule

// File: rtl/cop_irq_select.sv
module cop_irq_select
  import cop_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample,
  input  logic            idis,
  input  logic [NSRC-1:0] qual,
  output logic [NSRC-1:0] won,
  output logic            any_won
);
  logic [NSRC-1:0] cand;

  assign cand    = pick_winner(qual, idis);
  assign won     = sample ? cand : '0;
  assign any_won = |won;

  a_r5_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(won));
  a_r4_masked_none: assert property (@(posedge clk) disable iff (!rst_n)
    (idis && !qual[SRC_NMI]) |-> !any_won);
  a_r3_nmi_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && qual[SRC_NMI]) |-> won[SRC_NMI]);
endmodule

// File: rtl/cop_irq_srcbank.sv
module cop_irq_srcbank
  import cop_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] won,
  input  logic            wr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] clr_q,
  output logic [NSRC-1:0] flag_q
);
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        clr_q[k]  <= 1'b0;
        flag_q[k] <= 1'b0;
      end else if (won[k]) begin
        clr_q[k]  <= 1'b1;
        flag_q[k] <= 1'b1;
      end else if (wr) begin
        clr_q[k]  <= wdata[k];
        if (wdata[k]) flag_q[k] <= 1'b0;
      end
    end

    a_r9_take_over_write: assert property (@(posedge clk) disable iff (!rst_n)
      won[k] |=> (clr_q[k] && flag_q[k]));
  end
endmodule

// File: rtl/cop_irq_arbiter.sv
module cop_irq_arbiter
  import cop_irq_pkg::*;
#(
  parameter int VEC_W  = 16,
  parameter int BANK_W = 8,
  parameter int I_BIT  = 2,
  parameter int D_BIT  = 3,
  parameter int B_BIT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic             hold_i,
  input  logic             nmi_req_i,
  input  logic             tmr_req_i,
  input  logic             dma_req_i,
  input  logic             hirq_req_i,
  input  logic [2:0]       mask_en_i,
  input  logic             clr_we_i,
  input  logic [3:0]       clr_wdata_i,
  input  logic [VEC_W-1:0] nmi_vec_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             idis_i,
  input  logic             emu_i,
  input  logic [7:0]       p_i,
  output logic             take_o,
  output logic             wake_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [3:0]       flags_o,
  output logic [3:0]       clr_o,
  output logic [BANK_W-1:0] pbank_o,
  output logic [7:0]       p_new_o,
  output logic [7:0]       p_push_o,
  output logic             push_bank_o
);
  logic [NSRC-1:0] req_all, en_all, qual, won;
  logic            sample, any_won;

  assign req_all = {hirq_req_i, dma_req_i, tmr_req_i, nmi_req_i};
  assign en_all  = {mask_en_i, 1'b1};
  assign sample  = boundary_i & ~hold_i;

  cop_irq_srcbank u_bank (
    .clk(clk), .rst_n(rst_n), .won(won), .wr(clr_we_i),
    .wdata(clr_wdata_i), .clr_q(clr_o), .flag_q(flags_o)
  );

  cop_irq_qualify u_qual (
    .req(req_all), .en(en_all), .clr(clr_o), .qual(qual)
  );

  cop_irq_select u_sel (
    .clk(clk), .rst_n(rst_n), .sample(sample), .idis(idis_i),
    .qual(qual), .won(won), .any_won(any_won)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o      <= 1'b0;
      wake_o      <= 1'b0;
      vec_o       <= '0;
      p_new_o     <= 8'h34;
      p_push_o    <= 8'h34;
      push_bank_o <= 1'b0;
    end else begin
      take_o <= any_won;
      wake_o <= any_won;
      if (any_won) begin
        vec_o       <= won[SRC_NMI] ? nmi_vec_i : irq_vec_i;
        p_new_o     <= entry_status(p_i, I_BIT, D_BIT);
        p_push_o    <= stacked_status(p_i, emu_i, B_BIT);
        push_bank_o <= ~emu_i;
      end
    end
  end

  assign pbank_o = '0;

  a_r2_no_sample_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i || !boundary_i) |=> !take_o);
  a_r3_nmi_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && !hold_i && nmi_req_i && !clr_o[0]) |=> (take_o && vec_o == $past(nmi_vec_i)));
  a_r4_idis_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary_i && idis_i && !(nmi_req_i && !clr_o[0])) |=> !take_o);
  a_r7_wake_tracks_take: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o == take_o);
  a_r8_entry_values: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pbank_o == '0 && p_new_o[I_BIT] && !p_new_o[D_BIT]));
  a_r6_once_per_source: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(clr_we_i)) |-> ($countones(clr_o) >= 1));
endmodule

// File: tb/test_cop_irq_arbiter.sv
module test_cop_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boundary_i = 0, hold_i = 0;
  logic        nmi_req_i = 0, tmr_req_i = 0, dma_req_i = 0, hirq_req_i = 0;
  logic [2:0]  mask_en_i = 0;
  logic        clr_we_i = 0;
  logic [3:0]  clr_wdata_i = 0;
  logic [15:0] nmi_vec_i = 16'hA55A, irq_vec_i = 16'h1234;
  logic        idis_i = 0, emu_i = 1;
  logic [7:0]  p_i = 8'h00;
  logic        take_o, wake_o, push_bank_o;
  logic [15:0] vec_o;
  logic [3:0]  flags_o, clr_o;
  logic [7:0]  pbank_o, p_new_o, p_push_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cop_irq_arbiter i_cop_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .hold_i(hold_i),
    .nmi_req_i(nmi_req_i), .tmr_req_i(tmr_req_i), .dma_req_i(dma_req_i),
    .hirq_req_i(hirq_req_i), .mask_en_i(mask_en_i), .clr_we_i(clr_we_i),
    .clr_wdata_i(clr_wdata_i), .nmi_vec_i(nmi_vec_i), .irq_vec_i(irq_vec_i),
    .idis_i(idis_i), .emu_i(emu_i), .p_i(p_i), .take_o(take_o), .wake_o(wake_o),
    .vec_o(vec_o), .flags_o(flags_o), .clr_o(clr_o), .pbank_o(pbank_o),
    .p_new_o(p_new_o), .p_push_o(p_push_o), .push_bank_o(push_bank_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one boundary cycle; sample 1 ns after the capturing edge
  task automatic step_boundary();
    @(negedge clk) boundary_i = 1;
    @(posedge clk) #1;
    @(negedge clk) boundary_i = 0;
  endtask

  task automatic write_clr(input logic [3:0] d);
    @(negedge clk) begin clr_we_i = 1; clr_wdata_i = d; end
    @(negedge clk) clr_we_i = 0;
  endtask

  task automatic clear_all();
    write_clr(4'hF);
    write_clr(4'h0);
  endtask

  task automatic t_reset();
    check("R1 take", take_o, 0);
    check("R1 wake", wake_o, 0);
    check("R1 flags", flags_o, 0);
    check("R1 clr", clr_o, 0);
    check("R1 vec", vec_o, 16'h0000);
  endtask

  task automatic t_nmi();
    @(negedge clk) begin idis_i = 1; nmi_req_i = 1; tmr_req_i = 1; mask_en_i = 3'b111; end
    step_boundary();
    check("R3 take", take_o, 1);
    check("R7 wake", wake_o, 1);
    check("R3 vec", vec_o, 16'hA55A);
    check("R3 flag", flags_o, 4'b0001);
    check("R3 clr", clr_o, 4'b0001);
    step_boundary();
    check("R3 fires once", take_o, 0);
    check("R7 wake low", wake_o, 0);
    @(negedge clk) begin nmi_req_i = 0; tmr_req_i = 0; end
    clear_all();
    check("R9 write clears flag", flags_o, 0);
  endtask

  task automatic t_hold();
    @(negedge clk) begin idis_i = 0; tmr_req_i = 1; mask_en_i = 3'b001; hold_i = 1; end
    step_boundary();
    check("R2 hold blocks", take_o, 0);
    @(negedge clk) hold_i = 0;
    @(posedge clk) #1;
    check("R2 no boundary", take_o, 0);
    check("R2 flags untouched", flags_o, 0);
  endtask

  task automatic t_mask();
    @(negedge clk) begin idis_i = 1; tmr_req_i = 1; dma_req_i = 1; hirq_req_i = 1; mask_en_i = 3'b111; end
    step_boundary();
    check("R4 masked", take_o, 0);
    check("R4 flags", flags_o, 0);
  endtask

  task automatic t_prio();
    @(negedge clk) begin idis_i = 0; p_i = 8'h00; end
    step_boundary();
    check("R5 timer first", flags_o, 4'b0010);
    check("R6 shared vec", vec_o, 16'h1234);
    check("R10 pulse", take_o, 1);
    step_boundary();
    check("R5 dma second", flags_o, 4'b0110);
    step_boundary();
    check("R5 host third", flags_o, 4'b1110);
    check("R6 clr bits", clr_o, 4'b1110);
    step_boundary();
    check("R6 no retake", take_o, 0);
    clear_all();
    @(negedge clk) mask_en_i = 3'b110;
    step_boundary();
    check("R5 disabled timer skipped", flags_o, 4'b0100);
    write_clr(4'b0000);
    step_boundary();
    check("R6 rearmed dma", flags_o, 4'b0100);
    check("R6 rearm take", take_o, 1);
    @(negedge clk) begin tmr_req_i = 0; dma_req_i = 0; hirq_req_i = 0; end
    clear_all();
  endtask

  task automatic t_single_pulse();
    @(negedge clk) begin dma_req_i = 1; mask_en_i = 3'b010; boundary_i = 1; end
    @(posedge clk) #1;
    check("R10 first pulse", take_o, 1);
    @(posedge clk) #1;
    check("R10 no second pulse", take_o, 0);
    @(negedge clk) begin boundary_i = 0; dma_req_i = 0; end
    clear_all();
  endtask

  task automatic t_entry();
    @(negedge clk) begin tmr_req_i = 1; mask_en_i = 3'b001; p_i = 8'h1C; emu_i = 1; end
    step_boundary();
    check("R8 bank", pbank_o, 8'h00);
    check("R8 p_new emu", p_new_o, 8'h14);
    check("R8 push emu", p_push_o, 8'h0C);
    check("R8 no bank push", push_bank_o, 0);
    clear_all();
    @(negedge clk) emu_i = 0;
    step_boundary();
    check("R8 push native", p_push_o, 8'h1C);
    check("R8 bank push", push_bank_o, 1);
    @(negedge clk) tmr_req_i = 0;
    clear_all();
  endtask

  task automatic t_collide();
    @(negedge clk) begin
      nmi_req_i = 1; boundary_i = 1; clr_we_i = 1; clr_wdata_i = 4'b1000;
    end
    @(posedge clk) #1;
    check("R9 take wins clr", clr_o, 4'b1001);
    check("R9 take wins flag", flags_o, 4'b0001);
    @(negedge clk) begin boundary_i = 0; clr_we_i = 0; nmi_req_i = 0; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1;
    t_nmi();
    t_hold();
    t_mask();
    t_prio();
    t_single_pulse();
    t_entry();
    t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule